// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Programmable Triggers

This block holds the two data queues that sit between a UART's serial shifters and the host bus. The transmit queue takes bytes from the host and hands them to the transmit shifter; the receive queue takes bytes plus per-byte line-error flags from the receive shifter and hands them to the host. Each queue is 128 entries deep by default, and its current fill level is available as a plain output for the host to read.

Each fill level is compared against a threshold that the host sets. The results drive two interrupt requests:
- The receive request is raised when enough data has arrived.
- The transmit request is raised when the queue has drained far enough to accept more.

The block also produces three status outputs:
- A summary bit that says whether any byte still held in the receive queue carries an error.
- A sticky overrun flag.
- A transmitter-idle flag that is set only when the transmit queue and the transmit shifter are both empty.

The transmitter and the receiver each have their own enable input.

Data moves over valid/ready handshakes; a transfer happens on a rising clock edge where valid and ready are both high.
- Transmit input: back-pressure is applied by dropping `tx_in_ready` while the queue is full.
- Both output sides: the consumer stalls the queue by holding its ready input low. Data and valid stay stable until the transfer happens.
- Receive input: it has no ready, because a serial receiver cannot be stalled. A byte that arrives while the queue is full is lost and recorded as an overrun.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue holds up to DEPTH (default 128) entries in first-in first-out order. `tx_level` and `rx_level` give the number of stored entries, and each updates on the clock edge after the transfer that changes it.
- R2: `tx_in_ready` is low exactly when `tx_level` equals DEPTH. While it is low, a byte offered on the transmit input is not stored.
- R3: A receive byte offered while `rx_level` equals DEPTH is discarded and sets `rx_overrun`. The flag stays set until a cycle with `rx_overrun_clr` high and no new overrun in that same cycle; an overrun in the clearing cycle keeps it set.
- R4: `rx_irq` is high when `rx_level` is nonzero and `rx_level` >= `rx_trig`. Threshold values 0 and 1 therefore behave alike, which gives 127 distinct receive thresholds from 1 to 127.
- R5: `tx_irq` is high when `tx_level` <= `tx_trig`, which gives 128 distinct transmit thresholds from 0 to 127.
- R6: `tx_idle` is high exactly when `tx_level` is 0 and `tx_shift_busy` is low.
- R7: Every receive byte is stored with its 3-bit error field: bit 0 parity, bit 1 framing, bit 2 break. The field is returned on `rx_out_err` alongside the byte. `rx_bad` is high exactly when at least one stored entry has a nonzero error field.
- R8: Enable inputs:
  - While `tx_en` is low, `tx_out_valid` is low and the transmit queue keeps its contents.
  - While `rx_en` is low, bytes offered on the receive input are discarded without setting `rx_overrun`, and `rx_level` does not grow.
- R9: A push and a pop accepted on the same edge leave that queue's level unchanged.
- R10: After reset both levels are 0, `rx_overrun`, `rx_bad` and `rx_irq` are low, and `tx_idle` is high when `tx_shift_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_in_data | input | DATA_W | Transmit byte from host |
| tx_out_valid | output | 1 | Byte available for the transmit shifter |
| tx_out_ready | input | 1 | Transmit shifter takes the byte |
| tx_out_data | output | DATA_W | Oldest transmit byte |
| tx_shift_busy | input | 1 | Transmit shift register holds data |
| tx_trig | input | LVL_W | Transmit interrupt threshold |
| tx_level | output | LVL_W | Transmit fill level |
| tx_irq | output | 1 | Transmit threshold request |
| tx_idle | output | 1 | Queue and shifter both empty |
| rx_in_valid | input | 1 | Receive shifter delivers a byte |
| rx_in_data | input | DATA_W | Received byte |
| rx_in_err | input | ERR_W | Received byte's error flags |
| rx_out_valid | output | 1 | Received byte available for host |
| rx_out_ready | input | 1 | Host takes the byte |
| rx_out_data | output | DATA_W | Oldest received byte |
| rx_out_err | output | ERR_W | Its error flags |
| rx_trig | input | LVL_W | Receive interrupt threshold |
| rx_level | output | LVL_W | Receive fill level |
| rx_irq | output | 1 | Receive threshold request |
| rx_bad | output | 1 | Some stored byte has an error |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_overrun_clr | input | 1 | Clears the overrun flag |

## Verification
Each queue is filled one entry at a time from empty to full with byte values computed from the index. At every level the bench sweeps all 128 threshold values and compares both interrupt requests with the arithmetic rule, which separates an off-by-one in the comparison from a wrong direction of comparison. The receive errors use a sparse pattern in which different flag bits sit at irregular positions. Draining the queue then checks that the bad-data summary clears only after the last errored entry has left, not at the first errored pop. Further patterns cover:
- a push into a full queue and an overrun in the same cycle as its clear;
- pushes offered while a side is disabled;
- a push and a pop on the same edge.

Together these separate dropped data from stored data and the set priority from the clear priority.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic {
    CMP_AT_OR_ABOVE = 1'b0,
    CMP_AT_OR_BELOW = 1'b1
  } cmp_mode_e;

  localparam int DEF_DEPTH  = 128;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ERR_W  = 3;
endpackage

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/err_tally.sv
module err_tally #(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic any
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (inc && !dec)  cnt <= cnt + 1'b1;
    else if (dec && !inc)  cnt <= cnt - 1'b1;
  end

  assign any = (cnt != '0);
endmodule

// File: rtl/lvl_cmp.sv
module lvl_cmp
  import uart_fifo_pkg::*;
#(
  parameter int        LW   = 8,
  parameter cmp_mode_e MODE = CMP_AT_OR_ABOVE
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig,
  output logic          hit
);
  generate
    if (MODE == CMP_AT_OR_ABOVE) begin : g_above
      assign hit = (level != '0) && (level >= trig);
    end else begin : g_below
      assign hit = (level <= trig);
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int DATA_W = DEF_DATA_W,
  parameter int ERR_W  = DEF_ERR_W,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int RX_W  = DATA_W + ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_shift_busy,
  input  logic [LVL_W-1:0]  tx_trig,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_irq,
  output logic              tx_idle,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic [ERR_W-1:0]  rx_in_err,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic [ERR_W-1:0]  rx_out_err,
  input  logic [LVL_W-1:0]  rx_trig,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_irq,
  output logic              rx_bad,
  output logic              rx_overrun,
  input  logic              rx_overrun_clr
);
  // transmit side
  logic tx_full, tx_empty, tx_push, tx_pop;

  assign tx_in_ready  = !tx_full;
  assign tx_out_valid = tx_en && !tx_empty;
  assign tx_push      = tx_in_valid && tx_in_ready;
  assign tx_pop       = tx_out_valid && tx_out_ready;
  assign tx_idle      = tx_empty && !tx_shift_busy;

  fifo_core #(.DEPTH(DEPTH), .W(DATA_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(tx_in_data),
    .pop(tx_pop), .head(tx_out_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  lvl_cmp #(.LW(LVL_W), .MODE(CMP_AT_OR_BELOW)) u_tx_cmp (
    .level(tx_level), .trig(tx_trig), .hit(tx_irq)
  );

  // receive side
  logic            rx_full, rx_empty, rx_push, rx_pop, rx_drop;
  logic [RX_W-1:0] rx_head;

  assign rx_push      = rx_in_valid && rx_en && !rx_full;
  assign rx_drop      = rx_in_valid && rx_en && rx_full;
  assign rx_out_valid = !rx_empty;
  assign rx_pop       = rx_out_valid && rx_out_ready;
  assign rx_out_data  = rx_head[RX_W-1:ERR_W];
  assign rx_out_err   = rx_head[ERR_W-1:0];

  fifo_core #(.DEPTH(DEPTH), .W(RX_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data({rx_in_data, rx_in_err}),
    .pop(rx_pop), .head(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  lvl_cmp #(.LW(LVL_W), .MODE(CMP_AT_OR_ABOVE)) u_rx_cmp (
    .level(rx_level), .trig(rx_trig), .hit(rx_irq)
  );

  err_tally #(.DEPTH(DEPTH)) u_bad (
    .clk(clk), .rst_n(rst_n),
    .inc(rx_push && (rx_in_err != '0)),
    .dec(rx_pop && (rx_out_err != '0)),
    .any(rx_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rx_overrun <= 1'b0;
    else if (rx_drop)        rx_overrun <= 1'b1;
    else if (rx_overrun_clr) rx_overrun <= 1'b0;
  end
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [LVL_W-1:0]  tx_level,
  input logic              rx_in_valid,
  input logic              rx_out_valid,
  input logic              rx_out_ready,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_bad,
  input logic              rx_overrun,
  input logic              rx_overrun_clr
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH))); // R1

  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LVL_W'(DEPTH) && !(tx_out_valid && tx_out_ready))
      |=> tx_level == LVL_W'(DEPTH)); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_overrun_clr) |=> rx_overrun); // R3

  AST_BAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_bad); // R7

  AST_RX_OFF_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !(rx_out_valid && rx_out_ready)) |=> $stable(rx_level)); // R8

  AST_RX_OFF_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_overrun) |=> !rx_overrun); // R8

  AST_TX_BOTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && tx_out_valid && tx_out_ready)
      |=> $stable(tx_level)); // R9
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_chk (.*);

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/100ps
module uart_fifo_pair_bench;
  localparam int DEPTH = 128;
  localparam int LW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en, rx_en, tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic [7:0] tx_in_data, tx_out_data, rx_in_data, rx_out_data;
  logic tx_shift_busy, tx_irq, tx_idle;
  logic [LW-1:0] tx_trig, tx_level, rx_trig, rx_level;
  logic rx_in_valid, rx_out_valid, rx_out_ready, rx_irq, rx_bad, rx_overrun, rx_overrun_clr;
  logic [2:0] rx_in_err, rx_out_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txv(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction
  function automatic logic [7:0] rxv(input int i);
    return 8'((i * 53 + 200) % 256);
  endfunction
  function automatic logic [2:0] rxe(input int i);
    if (i % 11 == 4)  return 3'b001;
    if (i % 17 == 9)  return 3'b010;
    if (i == 120)     return 3'b100;
    return 3'b000;
  endfunction
  function automatic bit err_after(input int first);
    for (int k = first; k < DEPTH; k++) if (rxe(k) != 0) return 1;
    return 0;
  endfunction

  task automatic sweep_tx(input int lvl);
    for (int t = 0; t < DEPTH; t++) begin
      tx_trig = LW'(t);
      #0.1;
      chk(tx_irq == (lvl <= t), "R5 tx_irq", int'(tx_irq), int'(lvl <= t));
    end
  endtask
  task automatic sweep_rx(input int lvl);
    for (int t = 0; t < DEPTH; t++) begin
      rx_trig = LW'(t);
      #0.1;
      chk(rx_irq == (lvl != 0 && lvl >= t), "R4 rx_irq", int'(rx_irq), int'(lvl != 0 && lvl >= t));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    tx_en = 1; rx_en = 1; tx_in_valid = 0; tx_in_data = 0; tx_out_ready = 0;
    tx_shift_busy = 0; tx_trig = 0; rx_trig = 0; rx_in_valid = 0; rx_in_data = 0;
    rx_in_err = 0; rx_out_ready = 0; rx_overrun_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R10 reset state
    chk(tx_level == 0, "R10 tx_level", int'(tx_level), 0);
    chk(rx_level == 0, "R10 rx_level", int'(rx_level), 0);
    chk(tx_idle == 1, "R10 tx_idle", int'(tx_idle), 1);
    chk(rx_overrun == 0, "R10 rx_overrun", int'(rx_overrun), 0);
    chk(rx_bad == 0, "R10 rx_bad", int'(rx_bad), 0);
    chk(rx_irq == 0, "R10 rx_irq", int'(rx_irq), 0);
    sweep_tx(0);
    sweep_rx(0);

    // transmit fill
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tx_in_valid = 1; tx_in_data = txv(i);
      #1 chk(tx_in_ready == 1, "R2 ready while not full", int'(tx_in_ready), 1);
      @(posedge clk); #1;
      tx_in_valid = 0;
      chk(tx_level == LW'(i + 1), "R1 tx_level fill", int'(tx_level), i + 1);
      chk(tx_idle == 0, "R6 tx_idle with data", int'(tx_idle), 0);
      sweep_tx(i + 1);
    end
    @(negedge clk);
    tx_in_valid = 1; tx_in_data = 8'hEE;
    #1 chk(tx_in_ready == 0, "R2 ready when full", int'(tx_in_ready), 0);
    @(posedge clk); #1;
    tx_in_valid = 0;
    chk(tx_level == LW'(DEPTH), "R2 full level holds", int'(tx_level), DEPTH);

    // transmit disable
    @(negedge clk);
    tx_en = 0; tx_out_ready = 1;
    #1 chk(tx_out_valid == 0, "R8 tx_out_valid disabled", int'(tx_out_valid), 0);
    @(posedge clk); #1;
    chk(tx_level == LW'(DEPTH), "R8 tx disabled keeps data", int'(tx_level), DEPTH);
    tx_out_ready = 0;

    // transmit drain
    @(negedge clk) tx_en = 1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i != 0) @(negedge clk);
      #1;
      chk(tx_out_valid == 1, "R1 tx_out_valid", int'(tx_out_valid), 1);
      chk(tx_out_data == txv(i), "R1 tx order", int'(tx_out_data), int'(txv(i)));
      tx_out_ready = 1;
      @(posedge clk); #1;
      tx_out_ready = 0;
      chk(tx_level == LW'(DEPTH - 1 - i), "R1 tx_level drain", int'(tx_level), DEPTH - 1 - i);
    end
    tx_shift_busy = 1; #1;
    chk(tx_idle == 0, "R6 tx_idle shifter busy", int'(tx_idle), 0);
    tx_shift_busy = 0; #1;
    chk(tx_idle == 1, "R6 tx_idle all empty", int'(tx_idle), 1);

    // transmit simultaneous push and pop
    @(negedge clk) begin tx_in_valid = 1; tx_in_data = 8'h5A; end
    @(negedge clk) begin tx_in_data = 8'hA5; tx_out_ready = 1; end
    @(posedge clk); #1;
    tx_in_valid = 0; tx_out_ready = 0;
    chk(tx_level == 1, "R9 tx push+pop level", int'(tx_level), 1);
    chk(tx_out_data == 8'hA5, "R9 tx head after push+pop", int'(tx_out_data), 'hA5);
    @(negedge clk) tx_out_ready = 1;
    @(posedge clk); #1 tx_out_ready = 0;

    // receive fill
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rx_in_valid = 1; rx_in_data = rxv(i); rx_in_err = rxe(i);
      @(posedge clk); #1;
      rx_in_valid = 0;
      chk(rx_level == LW'(i + 1), "R1 rx_level fill", int'(rx_level), i + 1);
      chk(rx_bad == (err_after(0) && (i >= 4)), "R7 rx_bad fill", int'(rx_bad), int'(i >= 4));
      sweep_rx(i + 1);
    end
    chk(rx_overrun == 0, "R3 no overrun before full", int'(rx_overrun), 0);

    // receive overrun
    @(negedge clk) begin rx_in_valid = 1; rx_in_data = 8'h11; rx_in_err = 0; end
    @(posedge clk); #1 rx_in_valid = 0;
    chk(rx_overrun == 1, "R3 overrun set", int'(rx_overrun), 1);
    chk(rx_level == LW'(DEPTH), "R3 dropped byte", int'(rx_level), DEPTH);
    @(posedge clk); #1;
    chk(rx_overrun == 1, "R3 overrun sticky", int'(rx_overrun), 1);
    @(negedge clk) begin rx_in_valid = 1; rx_overrun_clr = 1; end
    @(posedge clk); #1 begin rx_in_valid = 0; rx_overrun_clr = 0; end
    chk(rx_overrun == 1, "R3 set wins over clear", int'(rx_overrun), 1);
    @(negedge clk) rx_overrun_clr = 1;
    @(posedge clk); #1 rx_overrun_clr = 0;
    chk(rx_overrun == 0, "R3 overrun cleared", int'(rx_overrun), 0);

    // receive drain
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); #1;
      chk(rx_out_valid == 1, "R1 rx_out_valid", int'(rx_out_valid), 1);
      chk(rx_out_data == rxv(i), "R1 rx order", int'(rx_out_data), int'(rxv(i)));
      chk(rx_out_err == rxe(i), "R7 rx_out_err", int'(rx_out_err), int'(rxe(i)));
      rx_out_ready = 1;
      @(posedge clk); #1;
      rx_out_ready = 0;
      chk(rx_level == LW'(DEPTH - 1 - i), "R1 rx_level drain", int'(rx_level), DEPTH - 1 - i);
      chk(rx_bad == err_after(i + 1), "R7 rx_bad drain", int'(rx_bad), int'(err_after(i + 1)));
    end

    // receive disable
    @(negedge clk) begin rx_en = 0; rx_in_valid = 1; rx_in_err = 3'b010; end
    @(posedge clk); #1 rx_in_valid = 0;
    chk(rx_level == 0, "R8 rx disabled drops", int'(rx_level), 0);
    chk(rx_bad == 0, "R8 rx disabled no bad", int'(rx_bad), 0);
    chk(rx_overrun == 0, "R8 rx disabled no overrun", int'(rx_overrun), 0);

    // receive simultaneous push and pop
    @(negedge clk) begin rx_en = 1; rx_in_valid = 1; rx_in_data = 8'h21; rx_in_err = 3'b001; end
    @(negedge clk) begin rx_in_data = 8'h42; rx_in_err = 0; rx_out_ready = 1; end
    @(posedge clk); #1 begin rx_in_valid = 0; rx_out_ready = 0; end
    chk(rx_level == 1, "R9 rx push+pop level", int'(rx_level), 1);
    chk(rx_out_data == 8'h42, "R9 rx head", int'(rx_out_data), 'h42);
    chk(rx_bad == 0, "R7 errored entry popped", int'(rx_bad), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule